// File: doc/BRIEF.md
# Interleaved Stripe Hamming Page Codec

This block moves a 256-byte page over a noisy one-bit serial medium. To send, it first runs a CRC-32 over the page. It then splits the page and the CRC into sixteen stripes, protects each stripe with a single-error-correcting Hamming code, and sends the codewords interleaved bit by bit. Each line bit that follows belongs to the next stripe. A burst of errors on the line therefore lands as single errors in separate stripes.

To receive, it takes the line bits one per valid strobe and rebuilds the stripes. A bit flagged as erased is taken as zero. Each stripe is corrected from its syndrome, the CRC-32 is recomputed over the corrected page, and a one-cycle done pulse reports whether the page passed and which stripes needed a correction. The page buffer is loaded before a send and read back after a receive through a byte-wide port.

Top module: `stripe_page_codec`

## Requirements
- R1: While idle, `pg_we` writes `pg_wdata` to byte `pg_addr`. `pg_rdata` always shows byte `pg_addr` without a clock delay. A write while busy is ignored.
- R2: The CRC-32 uses the reflected polynomial 0xEDB88320, starts at 0xFFFFFFFF and is inverted at the end. It runs over page bit b = 8*byte + bit, fed byte 0 first and least significant bit first. CRC bit c goes into stripe c/2 as information bit 128 + (c mod 2).
- R3: A stripe codeword has positions 1..138, with check bits at positions 1, 2, 4, ..., 128. Information bits 0..129 fill the other positions in ascending order. Information bit k < 128 of stripe s is page bit 128*s + k. Check bit 2^j is the XOR of all information bits whose position has bit j set.
- R4: A send started by `tx_start` drives `tx_valid` for exactly 2208 consecutive cycles. Line bit i, sent on `tx_bit`, is position i/16 + 1 of stripe i mod 16.
- R5: A received bit with `rx_erase` high is taken as 0, whatever `rx_bit` is. An erased bit whose true value is 0 causes no correction.
- R6: After `rx_start`, 2208 bits are taken, one per cycle with `rx_valid` high, in the R4 order. A single wrong bit per stripe is corrected, whether it sits in page data, CRC or check bits. Any run of up to 16 consecutive wrong line bits is therefore repaired.
- R7: Bit s of `fix_mask` is set after a receive exactly when stripe s had a nonzero syndrome. It holds until the next `rx_start`.
- R8: `crc_ok` is 1 after a receive exactly when the CRC recomputed over the corrected page equals the corrected received CRC. Two errors in one stripe give `crc_ok` = 0.
- R9: `done` is a one-cycle pulse one cycle after the last CRC step of a receive. `busy` is high from the accepted start until `done`, and low while `done` is high.
- R10: `tx_start` and `rx_start` are ignored while busy. `tx_start` wins if both arrive together while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_we | input | 1 | Page byte write strobe |
| pg_addr | input | 8 | Page byte address |
| pg_wdata | input | 8 | Page byte write data |
| pg_rdata | output | 8 | Page byte at pg_addr |
| tx_start | input | 1 | Begin encoding and sending the page |
| tx_valid | output | 1 | tx_bit carries a line bit |
| tx_bit | output | 1 | Serial line bit out |
| rx_start | input | 1 | Begin receiving a page |
| rx_valid | input | 1 | rx_bit carries a line bit |
| rx_bit | input | 1 | Serial line bit in |
| rx_erase | input | 1 | Current line bit was lost |
| busy | output | 1 | A send or receive is in progress |
| done | output | 1 | Receive finished, status valid |
| crc_ok | output | 1 | Corrected page passed the CRC |
| fix_mask | output | 16 | Stripes that had a nonzero syndrome |

## Verification
The assertions assume that a receive always delivers a full 2208-bit stream. They also assume starts are pulsed only while `busy` is low, except where the stimulus tests the ignore rule on purpose. The bench meets this by driving complete streams and waiting for `busy` to fall before each new operation. It inserts idle gaps in `rx_valid` so that bit capture depends on the strobe and not on the cycle count. Error, erasure and burst patterns are placed against a reference line stream built in the bench, so each pattern's effect on stripes and syndromes is known in advance.

// File: rtl/stripe_codec_pkg.sv
// Shared constants and position helpers for the striped page codec.
// Assumes codeword positions fit in 8 bits (at most 255).
package stripe_codec_pkg;
    localparam int PAGE_BYTES = 256;
    localparam int PAGE_BITS  = PAGE_BYTES * 8;
    localparam int STRIPES    = 16;
    localparam int SEL_W      = $clog2(STRIPES);
    localparam int CRC_W      = 32;
    localparam int INFO_BITS  = PAGE_BITS / STRIPES + CRC_W / STRIPES;
    localparam int CHK_BITS   = 8;
    localparam int CW_BITS    = INFO_BITS + CHK_BITS;
    localparam int POS_W      = 8;
    localparam int LINE_BITS  = STRIPES * CW_BITS;
    localparam int CNT_W      = $clog2(LINE_BITS);
    localparam logic [CRC_W-1:0] CRC_POLY_R = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TCRC, ST_TPAR, ST_TSEND, ST_RRECV, ST_RFIX, ST_RCRC
    } phase_t;

    // True when position p holds a check bit (a power of two).
    function automatic logic is_check_pos(input logic [POS_W-1:0] p);
        return (p != '0) && ((p & (p - 1'b1)) == '0);
    endfunction

    // Information index carried at a non-check position p.
    function automatic logic [POS_W-1:0] info_index(input logic [POS_W-1:0] p);
        logic [POS_W-1:0] n;
        n = '0;
        for (int j = 0; j < POS_W; j++)
            if ((9'd1 << j) <= {1'b0, p}) n = n + 1'b1;
        return p - n - 1'b1;
    endfunction

    // Which check bit a power-of-two position p is.
    function automatic logic [2:0] check_index(input logic [POS_W-1:0] p);
        logic [2:0] r;
        r = '0;
        for (int j = 0; j < POS_W; j++)
            if (p[j]) r = 3'(j);
        return r;
    endfunction
endpackage

// File: rtl/crc32_bit_serial.sv
// One-bit-per-cycle reflected CRC-32 register.
// Assumes init and en are never needed in the same cycle; init wins.
module crc32_bit_serial
    import stripe_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_nxt
);
    logic [CRC_W-1:0] crc_q;

    // Next value after absorbing din.
    always_comb begin
        crc_nxt = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? CRC_POLY_R : '0);
    end

    // State register: preset to all ones, then one step per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc_q <= '1;
        else if (en)        crc_q <= crc_nxt;
    end
endmodule

// File: rtl/stripe_syndrome_bank.sv
// Sixteen per-stripe syndrome accumulators: each XORs in the positions
// of one-bits routed to it. Assumes val is already zero for zero bits.
module stripe_syndrome_bank
    import stripe_codec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic [SEL_W-1:0]         sel,
    input  logic [POS_W-1:0]         val,
    output logic [STRIPES*POS_W-1:0] syn_flat
);
    for (genvar g = 0; g < STRIPES; g++) begin : g_stripe
        // Accumulate the XOR of one-bit positions for stripe g.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                syn_flat[g*POS_W +: POS_W] <= '0;
            else if (en && sel == SEL_W'(g))
                syn_flat[g*POS_W +: POS_W] <= syn_flat[g*POS_W +: POS_W] ^ val;
        end
    end
endmodule

// File: rtl/stripe_page_codec.sv
// Page codec: CRC-32, 16 Hamming(138,130) stripes, bit-interleaved serial
// line. Assumes a receive delivers all 2208 bits and starts come when idle.
module stripe_page_codec
    import stripe_codec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_we,
    input  logic [7:0]         pg_addr,
    input  logic [7:0]         pg_wdata,
    output logic [7:0]         pg_rdata,
    input  logic               tx_start,
    output logic               tx_valid,
    output logic               tx_bit,
    input  logic               rx_start,
    input  logic               rx_valid,
    input  logic               rx_bit,
    input  logic               rx_erase,
    output logic               busy,
    output logic               done,
    output logic               crc_ok,
    output logic [STRIPES-1:0] fix_mask
);
    phase_t                   state;
    logic [CNT_W-1:0]         cnt;
    logic [7:0]               mem [PAGE_BYTES];
    logic [CRC_W-1:0]         crc_word;
    logic [CRC_W-1:0]         crc_nxt;
    logic [STRIPES*POS_W-1:0] syn_flat;

    logic [SEL_W-1:0] s;
    logic [POS_W-1:0] p, k, syn_cur, fk;
    logic pos_chk, info_bit, rx_b, line_last, page_last, fix_ok;
    logic syn_en, syn_clr, crc_init, crc_en, page_bit;
    logic [POS_W-1:0] syn_val;

    // Line-slot decode and shared data-path selects.
    always_comb begin
        s         = cnt[SEL_W-1:0];
        p         = cnt[CNT_W-1:SEL_W] + 1'b1;
        pos_chk   = is_check_pos(p);
        k         = info_index(p);
        info_bit  = k[7] ? crc_word[{s, k[0]}] : mem[{s, k[6:3]}][k[2:0]];
        rx_b      = rx_bit & ~rx_erase;
        line_last = (cnt == CNT_W'(LINE_BITS - 1));
        page_last = (cnt == CNT_W'(PAGE_BITS - 1));
        syn_cur   = syn_flat[s*POS_W +: POS_W];
        fk        = info_index(syn_cur);
        fix_ok    = (syn_cur != '0) && (syn_cur <= POS_W'(CW_BITS)) && !is_check_pos(syn_cur);
        page_bit  = mem[cnt[10:3]][cnt[2:0]];
        syn_en    = (state == ST_TPAR) || (state == ST_RRECV && rx_valid);
        syn_val   = (((state == ST_TPAR) ? (!pos_chk && info_bit) : rx_b)) ? p : '0;
        syn_clr   = (state == ST_IDLE) && (tx_start || rx_start);
        crc_init  = ((state == ST_IDLE) && tx_start) || ((state == ST_RFIX) && s == '1);
        crc_en    = (state == ST_TCRC) || (state == ST_RCRC);
        tx_valid  = (state == ST_TSEND);
        tx_bit    = pos_chk ? syn_cur[check_index(p)] : info_bit;
        busy      = (state != ST_IDLE);
        pg_rdata  = mem[pg_addr];
    end

    crc32_bit_serial i_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
        .din(page_bit), .crc_nxt(crc_nxt)
    );

    stripe_syndrome_bank i_syn (
        .clk(clk), .rst_n(rst_n), .clr(syn_clr), .en(syn_en),
        .sel(s), .val(syn_val), .syn_flat(syn_flat)
    );

    // Phase sequencer, CRC word, status and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            done     <= 1'b0;
            crc_ok   <= 1'b0;
            fix_mask <= '0;
            crc_word <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (tx_start) state <= ST_TCRC;
                    else if (rx_start) begin
                        state    <= ST_RRECV;
                        fix_mask <= '0;
                        crc_ok   <= 1'b0;
                    end
                end
                ST_TCRC: begin
                    cnt <= cnt + 1'b1;
                    if (page_last) begin
                        crc_word <= ~crc_nxt;
                        state    <= ST_TPAR;
                        cnt      <= '0;
                    end
                end
                ST_TPAR, ST_TSEND: begin
                    cnt <= cnt + 1'b1;
                    if (line_last) begin
                        state <= (state == ST_TPAR) ? ST_TSEND : ST_IDLE;
                        cnt   <= '0;
                    end
                end
                ST_RRECV: if (rx_valid) begin
                    cnt <= cnt + 1'b1;
                    if (!pos_chk && k[7]) crc_word[{s, k[0]}] <= rx_b;
                    if (line_last) begin
                        state <= ST_RFIX;
                        cnt   <= '0;
                    end
                end
                ST_RFIX: begin
                    cnt <= cnt + 1'b1;
                    if (syn_cur != '0) fix_mask[s] <= 1'b1;
                    if (fix_ok && fk[7]) crc_word[{s, fk[0]}] <= ~crc_word[{s, fk[0]}];
                    if (s == '1) begin
                        state <= ST_RCRC;
                        cnt   <= '0;
                    end
                end
                ST_RCRC: begin
                    cnt <= cnt + 1'b1;
                    if (page_last) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        crc_ok <= (~crc_nxt == crc_word);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Page buffer: host writes when idle, received data bits, corrections.
    always_ff @(posedge clk) begin
        if (state == ST_IDLE && pg_we)
            mem[pg_addr] <= pg_wdata;
        else if (state == ST_RRECV && rx_valid && !pos_chk && !k[7])
            mem[{s, k[6:3]}][k[2:0]] <= rx_b;
        else if (state == ST_RFIX && fix_ok && !fk[7])
            mem[{s, fk[6:3]}][fk[2:0]] <= ~mem[{s, fk[6:3]}][fk[2:0]];
    end

    // R9: done lasts one cycle and the block is idle while it is high.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    a_r9_done_idle:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R4: the send window is one unbroken run ending after the last line bit.
    a_r4_tx_contig:   assert property (@(posedge clk) disable iff (!rst_n)
                                       (tx_valid && !line_last) |=> tx_valid);
    a_r4_tx_stop:     assert property (@(posedge clk) disable iff (!rst_n)
                                       (tx_valid && line_last) |=> !tx_valid);
    // R7: the stripe mask holds while idle and no receive is starting.
    a_r7_mask_hold:   assert property (@(posedge clk) disable iff (!rst_n)
                                       (state == ST_IDLE && !rx_start) |=> $stable(fix_mask));
    // R8: a pass verdict appears only together with done.
    a_r8_ok_with_done: assert property (@(posedge clk) disable iff (!rst_n)
                                        $rose(crc_ok) |-> done);
endmodule

// File: tb/test_stripe_page_codec.sv
module test_stripe_page_codec;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_we = 1'b0, tx_start = 1'b0, rx_start = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, rx_erase = 1'b0;
    logic [7:0] pg_addr = '0, pg_wdata = '0, pg_rdata;
    logic tx_valid, tx_bit, busy, done, crc_ok;
    logic [15:0] fix_mask;

    int checks = 0;
    int errors = 0;
    logic [7:0] pg_ref [256];
    bit line_ref [2208];
    bit err_v [2208];
    bit era_v [2208];
    bit poke_busy = 0;
    bit exp_q [$];
    logic [16:0] st_q [$];

    always #5 clk = ~clk;

    stripe_page_codec i_stripe_page_codec (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_addr(pg_addr),
        .pg_wdata(pg_wdata), .pg_rdata(pg_rdata), .tx_start(tx_start),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .rx_start(rx_start),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_erase(rx_erase),
        .busy(busy), .done(done), .crc_ok(crc_ok), .fix_mask(fix_mask)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference line stream built from pg_ref (R2, R3, R4).
    task automatic build_line();
        logic [31:0] c;
        bit cw [139];
        int k;
        bit par;
        c = 32'hFFFFFFFF;
        for (int b = 0; b < 256; b++) begin
            c ^= {24'd0, pg_ref[b]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 139; p++) cw[p] = 0;
            k = 0;
            for (int p = 1; p <= 138; p++) begin
                if ((p & (p - 1)) != 0) begin
                    cw[p] = (k < 128) ? pg_ref[16*s + k/8][k%8] : c[2*s + k - 128];
                    k++;
                end
            end
            for (int j = 0; j < 8; j++) begin
                par = 0;
                for (int p = 1; p <= 138; p++) if (p[j]) par ^= cw[p];
                cw[1 << j] = par;
            end
            for (int p = 1; p <= 138; p++) line_ref[(p-1)*16 + s] = cw[p];
        end
    endtask

    task automatic clear_faults();
        for (int i = 0; i < 2208; i++) begin err_v[i] = 0; era_v[i] = 0; end
    endtask

    task automatic write_page();
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            pg_we = 1'b1; pg_addr = 8'(a); pg_wdata = pg_ref[a];
        end
        @(negedge clk);
        pg_we = 1'b0;
    endtask

    task automatic read_page(input string tag);
        int bad = 0;
        int first_a = 0;
        logic [7:0] got = '0;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            pg_addr = 8'(a);
            #1;
            if (pg_rdata !== pg_ref[a] && bad == 0) begin first_a = a; got = pg_rdata; end
            if (pg_rdata !== pg_ref[a]) bad++;
        end
        check(bad == 0, {tag, " page byte mismatch"}, int'(got), int'(pg_ref[first_a]));
    endtask

    task automatic run_tx();
        build_line();
        for (int i = 0; i < 2208; i++) exp_q.push_back(line_ref[i]);
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R4 line bit count", 2208 - exp_q.size(), 2208);
    endtask

    // Drive one receive; st_q must already hold the expected status.
    task automatic run_rx();
        build_line();
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        for (int i = 0; i < 2208; i++) begin
            if (i % 97 == 50) begin rx_valid = 1'b0; @(negedge clk); end
            rx_valid = 1'b1;
            rx_erase = era_v[i];
            rx_bit   = era_v[i] ? 1'b1 : (line_ref[i] ^ err_v[i]);
            if (poke_busy && i == 100) begin
                pg_we = 1'b1; pg_addr = 8'd0; pg_wdata = ~pg_ref[0];
                tx_start = 1'b1;
            end
            @(negedge clk);
            pg_we = 1'b0; tx_start = 1'b0;
        end
        rx_valid = 1'b0; rx_erase = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(st_q.size() == 0, "R9 done pulse seen", st_q.size(), 0);
    endtask

    // Scoreboard monitor: pops expected line bits and receive status.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0)
                check(0, "R10 unexpected tx bit", 1, 0);
            else
                check(tx_bit == exp_q.pop_front(), "R3 R4 line bit", tx_bit, !tx_bit);
        end
        if (rst_n && done) begin
            check(!busy, "R9 busy low at done", busy, 0);
            if (st_q.size() == 0)
                check(0, "R9 unexpected done", 1, 0);
            else begin
                logic [16:0] e;
                e = st_q.pop_front();
                check(crc_ok == e[16], "R8 crc_ok", crc_ok, e[16]);
                check(fix_mask == e[15:0], "R7 fix_mask", fix_mask, e[15:0]);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R9 watchdog busy", busy, 0);
        finish_run();
    end

    initial begin
        int m;
        clear_faults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !tx_valid, "R9 reset idle", {busy, done, tx_valid}, 0);
        check(!crc_ok && fix_mask == 0, "R7 R8 reset status", {crc_ok, fix_mask}, 0);

        // Pattern A: write, read back, send.
        for (int a = 0; a < 256; a++) pg_ref[a] = 8'(a * 37 + 11);
        write_page();
        read_page("R1 readback");
        run_tx();

        // Clean receive with write and tx_start pokes while busy (R1, R10).
        poke_busy = 1;
        st_q.push_back({1'b1, 16'h0000});
        run_rx();
        poke_busy = 0;
        read_page("R1 R10 clean receive");

        // Burst of 16 consecutive flips (R6).
        clear_faults();
        for (int j = 0; j < 16; j++) err_v[500 + j] = 1;
        st_q.push_back({1'b1, 16'hFFFF});
        run_rx();
        read_page("R6 burst repaired");

        // Erasures on true zeros cause no correction (R5).
        clear_faults();
        m = 0;
        for (int i = 1000; i < 2208 && m < 40; i++)
            if (!line_ref[i]) begin era_v[i] = 1; m++; end
        st_q.push_back({1'b1, 16'h0000});
        run_rx();
        read_page("R5 zero erasures");

        // Erased one in stripe 5, check bit error in stripe 7, CRC bit in 9.
        clear_faults();
        for (int i = 5; i < 2208; i += 16)
            if (line_ref[i]) begin era_v[i] = 1; break; end
        err_v[7 + 16*7]   = 1;
        err_v[9 + 16*136] = 1;
        st_q.push_back({1'b1, 16'h02A0});
        run_rx();
        read_page("R5 R6 mixed single errors");

        // Two errors in stripe 3: miscorrection must fail the CRC (R8).
        clear_faults();
        err_v[3 + 16*10] = 1;
        err_v[3 + 16*20] = 1;
        st_q.push_back({1'b0, 16'h0008});
        run_rx();

        // Pattern B: send after fresh write.
        clear_faults();
        for (int a = 0; a < 256; a++) pg_ref[a] = 8'(~a ^ (a << 3));
        write_page();
        run_tx();
        st_q.push_back({1'b1, 16'h0000});
        run_rx();
        read_page("R2 pattern B receive");

        finish_run();
    end
endmodule